// File: doc/BRIEF.md
# MDIO Management Master

This block lets a host run Clause 22 management reads and writes over an MDIO/MDC serial bus through three 32-bit registers. The registers are a status word, a command word and a read-data word. A single write to the command word holds the valid flag, PHY address, register address, write data and operation. That one write starts the whole transaction. The block then builds the management frame, generates MDC from the system clock, and drives MDIO. During the turnaround and data phase of a read it releases MDIO.

While a frame is on the wire, the busy flag in the status word is set. The host polls this flag before it issues the next command, and again before it fetches read data. A read returns the 16 bits sampled from the PHY. If the PHY did not pull the second turnaround bit low, an error flag is set next to that data.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the status word (offset 0x0) and the data word (offset 0xC) read 0, MDC is low and the MDIO output enable is low.
- R2: A host write to offset 0x8 is accepted only in these conditions: bit 31 is set, exactly one of bit 2 (read) and bit 1 (write) is set, and the block is idle. An accepted write makes status bit 3 (busy) read 1 from the next clock cycle.
- R3: A command write is ignored in three cases: bit 31 is clear, both operation bits are set, or neither is set (for example only bit 0 or bit 3 set). In these cases busy stays 0 and no MDC edge occurs.
- R4: A write sends these bits in order: 32 ones, start 01, opcode 01, the PHY address (command bits 29:25, MSB first), the register address (bits 24:20, MSB first), turnaround 10, then the 16 data bits (bits 19:4, MSB first).
- R5: A read sends the same header with opcode 10. The output enable is high for the first 46 bit times and low for the last 18.
- R6: When a read completes, bits 15:0 of the data word hold the 16 bits sampled on the rising MDC edges after the turnaround, first sample in bit 15. Bits 31:18 and bit 16 read 0.
- R7: Data-word bit 17 is set when the PHY leaves the second turnaround bit high. The bit is cleared when the next command is accepted, and the 16 data bits are kept until then.
- R8: A command written while busy is ignored and does not change the frame in progress.
- R9: The MDC period is 2*DIV_HALF system clocks. MDIO changes only when MDC falls, and it is sampled when MDC rises. MDC and the output enable stay low while idle.
- R10: Each transaction takes exactly 64 MDC cycles. Busy clears once the last bit has ended and, for a read, once the data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Host write strobe |
| busAddr | input | ADDR_W | Host register byte offset |
| busWdata | input | 32 | Host write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | MDIO value driven by the block |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the pad |

## Verification
Two events can meet on the same clock edge: the end of a frame, which drops busy, and a host command write. The bench holds a second command on the bus without pause from just after a first command is accepted until past the end of that frame. Every copy that arrives while busy must be dropped, and the copy in the first idle cycle must start a frame. The result is judged from the wire: exactly two frames appear, and the first matches the original command and the second the held one.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  localparam int FRAME_LEN    = 64;
  localparam int IDX_W        = $clog2(FRAME_LEN);
  localparam int PREAMBLE_LEN = 32;
  localparam int DATA_W       = 16;
  localparam int TA_FIRST     = 46;
  localparam int TA_SECOND    = 47;
  localparam int DATA_FIRST   = 48;

  localparam int OFS_STATUS = 'h0;
  localparam int OFS_CMD    = 'h8;
  localparam int OFS_RDATA  = 'hC;

  localparam int CMD_VALID_BIT = 31;
  localparam int CMD_RD_BIT    = 2;
  localparam int CMD_WR_BIT    = 1;
  localparam int STAT_BUSY_BIT = 3;
  localparam int RD_ERR_BIT    = 17;

  typedef struct packed {
    logic load;
    logic shiftOut;
    logic sample;
    logic finish;
  } mdioStrb_t;
endpackage

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdReq,
  output mdioStrb_t        strb,
  output logic             busy,
  output logic             mdc,
  output logic [IDX_W-1:0] bitIdx
);
  localparam int DIV_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  typedef enum logic {ST_IDLE, ST_RUN} state_t;
  state_t           state;
  logic [DIV_W-1:0] divCnt;
  logic             tick;
  logic             lastBit;

  assign tick    = (state == ST_RUN) && (divCnt == DIV_W'(DIV_HALF - 1));
  assign lastBit = (bitIdx == IDX_W'(FRAME_LEN - 1));
  assign busy    = (state == ST_RUN);

  always_comb begin
    strb.load     = cmdReq && (state == ST_IDLE);
    strb.sample   = tick && !mdc;
    strb.shiftOut = tick && mdc && !lastBit;
    strb.finish   = tick && mdc && lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      divCnt <= '0;
      mdc    <= 1'b0;
      bitIdx <= '0;
    end else if (strb.load) begin
      state  <= ST_RUN;
      divCnt <= '0;
      mdc    <= 1'b0;
      bitIdx <= '0;
    end else if (state == ST_RUN) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
      if (tick) mdc <= !mdc;
      if (strb.shiftOut) bitIdx <= bitIdx + 1'b1;
      if (strb.finish) begin
        state  <= ST_IDLE;
        bitIdx <= '0;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_datapath.sv
module mdio_mgmt_datapath
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdioStrb_t         strb,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              busy,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              mdioIn,
  output logic              cmdReq,
  output logic [31:0]       busRdata,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              rdErr
);
  logic [FRAME_LEN-1:0] txShift;
  logic [FRAME_LEN-1:0] txFrame;
  logic [DATA_W-1:0]    rxShift;
  logic [DATA_W-1:0]    rdData;
  logic                 isRead;
  logic                 taErr;
  logic                 wantRead;

  assign wantRead = busWdata[CMD_RD_BIT];
  assign cmdReq   = busWrEn && (busAddr == ADDR_W'(OFS_CMD)) && busWdata[CMD_VALID_BIT]
                    && (busWdata[CMD_RD_BIT] ^ busWdata[CMD_WR_BIT]);

  assign txFrame = {{PREAMBLE_LEN{1'b1}}, 2'b01, (wantRead ? 2'b10 : 2'b01),
                    busWdata[29:25], busWdata[24:20], 2'b10, busWdata[19:4]};

  assign mdioOut = txShift[FRAME_LEN-1];
  assign mdioOe  = busy && !(isRead && (bitIdx >= IDX_W'(TA_FIRST)));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
      rdData  <= '0;
      isRead  <= 1'b0;
      taErr   <= 1'b0;
      rdErr   <= 1'b0;
    end else begin
      if (strb.load) begin
        txShift <= txFrame;
        isRead  <= wantRead;
        taErr   <= 1'b0;
        rdErr   <= 1'b0;
      end else if (strb.shiftOut) begin
        txShift <= {txShift[FRAME_LEN-2:0], 1'b0};
      end
      if (strb.sample && isRead) begin
        if (bitIdx == IDX_W'(TA_SECOND)) taErr <= mdioIn;
        if (bitIdx >= IDX_W'(DATA_FIRST)) rxShift <= {rxShift[DATA_W-2:0], mdioIn};
      end
      if (strb.finish && isRead) begin
        rdData <= rxShift;
        rdErr  <= taErr;
      end
    end
  end

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(OFS_STATUS)) begin
      busRdata[STAT_BUSY_BIT] = busy;
    end else if (busAddr == ADDR_W'(OFS_RDATA)) begin
      busRdata[DATA_W-1:0] = rdData;
      busRdata[RD_ERR_BIT] = rdErr;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_mgmt_pkg::*;
#(
  parameter int DIV_HALF = 2,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);
  mdioStrb_t        strb;
  logic             busy;
  logic             cmdReq;
  logic             rdErr;
  logic [IDX_W-1:0] bitIdx;

  mdio_mgmt_ctrl #(.DIV_HALF(DIV_HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdReq(cmdReq), .strb(strb),
    .busy(busy), .mdc(mdc), .bitIdx(bitIdx)
  );

  mdio_mgmt_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .bitIdx(bitIdx), .busy(busy),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata), .mdioIn(mdioIn),
    .cmdReq(cmdReq), .busRdata(busRdata), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .rdErr(rdErr)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
module mdio_mgmt_checker
  import mdio_mgmt_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busy,
  input logic              mdc,
  input logic              mdioOut,
  input logic              mdioOe,
  input logic              rdErr
);
  logic cmdWr;
  assign cmdWr = busWrEn && (busAddr == ADDR_W'(OFS_CMD));

  AST_GOOD_CMD_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && busWdata[31] && (busWdata[2] ^ busWdata[1])) |=> busy); // R2

  AST_NO_VALID_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && !busWdata[31]) |=> !busy); // R3

  AST_BAD_OP_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWr && !busy && (busWdata[2] == busWdata[1])) |=> !busy); // R3

  AST_ERR_CLEARED_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !rdErr); // R7

  AST_MDIO_STABLE_MDC_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (busy && mdc && $past(mdc)) |-> $stable(mdioOut)); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe)); // R9

  AST_BUSY_ENDS_ON_MDC_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(mdc)); // R10
endmodule

bind mdio_mgmt_master mdio_mgmt_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata),
  .busy(busy), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .rdErr(rdErr)
);

// File: tb/mdio_mgmt_master_bench.sv
module mdio_mgmt_master_bench;
  localparam int DIV_HALF = 2;
  localparam int ADDR_W   = 4;
  localparam int NVEC     = 6;
  localparam logic [63:0] RD_MASK = 64'hFFFF_FFFF_FFFC_0000;

  // vector: {isRead, phy[4:0], reg[4:0], data[15:0], taHigh}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 5'd1,  5'd0,  16'hA5C3, 1'b0},
    {1'b0, 5'd31, 5'd31, 16'hFFFF, 1'b0},
    {1'b1, 5'd3,  5'd2,  16'h1234, 1'b0},
    {1'b1, 5'd16, 5'd17, 16'h8001, 1'b0},
    {1'b1, 5'd5,  5'd9,  16'h00FF, 1'b1},
    {1'b1, 5'd0,  5'd1,  16'h0000, 1'b0}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              mdc, mdioOut, mdioOe, mdioIn;

  int          checks = 0;
  int          errors = 0;
  int          riseIdx = 0;
  int          frameCnt = 0;
  logic [63:0] frameBits = '0, oeBits = '0, lastFrame = '0, lastOe = '0, prevFrame = '0;
  logic [63:0] phyWord = '0;

  always #4 clk = ~clk;

  mdio_mgmt_master #(.DIV_HALF(DIV_HALF), .ADDR_W(ADDR_W)) u_mdio_mgmt_master (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  assign mdioIn = mdioOe ? mdioOut : phyWord[63 - riseIdx];

  always @(posedge mdc) begin
    frameBits[63 - riseIdx] = mdioOut;
    oeBits[63 - riseIdx]    = mdioOe;
    if (riseIdx == 63) begin
      prevFrame = lastFrame;
      lastFrame = frameBits;
      lastOe    = oeBits;
      frameCnt  = frameCnt + 1;
      riseIdx   = 0;
    end else begin
      riseIdx = riseIdx + 1;
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog expired: act=hung exp=done");
    summary();
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input int addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = ADDR_W'(addr); busWdata = data; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = ADDR_W'(addr);
    #1 data = busRdata;
  endtask

  task automatic waitIdle();
    logic [31:0] st;
    st = 32'h8;
    while (st[3]) busRead(0, st);
  endtask

  function automatic logic [31:0] mkCmd(input logic rd, input logic [4:0] phy,
                                        input logic [4:0] rg, input logic [15:0] d);
    return {1'b1, 1'b0, phy, rg, d, 1'b0, rd, ~rd, 1'b0};
  endfunction

  function automatic logic [63:0] mkFrame(input logic rd, input logic [4:0] phy,
                                          input logic [4:0] rg, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, rg, 2'b10, d};
  endfunction

  initial begin
    logic [31:0] rv;
    logic [31:0] expData;
    int          fc;
    time         t1, t2;
    expData = '0;

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: reset state
    busRead(0, rv);  chk("R1 status", 64'(rv), 64'h0);
    busRead('hC, rv); chk("R1 data", 64'(rv), 64'h0);
    chk("R1 mdc/oe", {62'b0, mdc, mdioOe}, 64'h0);

    // Table walk: R2 R4 R5 R6 R7 R10
    for (int i = 0; i < NVEC; i++) begin
      logic        rd;
      logic [4:0]  phy, rg;
      logic [15:0] d;
      logic        ta;
      logic [63:0] expF;
      {rd, phy, rg, d, ta} = VEC[i];
      phyWord = {47'b0, ta, d};
      fc = frameCnt;
      busWrite('h8, mkCmd(rd, phy, rg, d));
      busRead(0, rv);
      chk("R2 busy after accept", 64'(rv), 64'h8);
      waitIdle();
      chk("R10 one frame of 64 MDC cycles", 64'(frameCnt - fc), 64'd1);
      expF = mkFrame(rd, phy, rg, d);
      if (rd) begin
        chk("R5 read header", lastFrame & RD_MASK, expF & RD_MASK);
        chk("R5 read oe window", lastOe, RD_MASK);
        expData = {14'b0, ta, 1'b0, d};
      end else begin
        chk("R4 write frame", lastFrame, expF);
        chk("R4 write oe", lastOe, 64'hFFFF_FFFF_FFFF_FFFF);
        expData[17] = 1'b0;
      end
      busRead('hC, rv);
      chk(ta ? "R7 error flag" : "R6 read data word", 64'(rv), 64'(expData));
    end

    // R7: error cleared on accept, data kept
    phyWord = {47'b0, 1'b1, 16'hBEEF};
    busWrite('h8, mkCmd(1'b1, 5'd2, 5'd3, 16'h0));
    waitIdle();
    busRead('hC, rv); chk("R7 error set", 64'(rv), 64'h0002_BEEF);
    busWrite('h8, mkCmd(1'b0, 5'd2, 5'd3, 16'h5555));
    busRead('hC, rv); chk("R7 error cleared on accept", 64'(rv), 64'h0000_BEEF);
    waitIdle();

    // R3: ignored commands
    fc = frameCnt;
    busWrite('h8, 32'h7FFF_FFF4);
    busWrite('h8, 32'h8000_0001);
    busWrite('h8, 32'h8000_0008);
    busWrite('h8, 32'h8123_4566);
    busWrite('h0, mkCmd(1'b0, 5'd1, 5'd1, 16'h1));
    repeat (20) @(negedge clk);
    busRead(0, rv);
    chk("R3 busy stays clear", 64'(rv), 64'h0);
    chk("R3 no mdc activity", {63'b0, mdc}, 64'h0);
    chk("R3 no frame", 64'(frameCnt - fc), 64'h0);

    // R9: MDC period and idle level
    busWrite('h8, mkCmd(1'b0, 5'd7, 5'd7, 16'h7));
    @(posedge mdc) t1 = $time;
    @(posedge mdc) t2 = $time;
    chk("R9 mdc period", 64'(t2 - t1), 64'(2 * DIV_HALF * 8));
    waitIdle();
    repeat (5) @(negedge clk);
    chk("R9 idle mdc/oe low", {62'b0, mdc, mdioOe}, 64'h0);

    // R8: command held on the bus during a frame and across its end
    fc = frameCnt;
    busWrite('h8, mkCmd(1'b0, 5'd9, 5'd4, 16'hC0DE));
    @(negedge clk);
    busAddr = ADDR_W'('h8);
    busWdata = mkCmd(1'b0, 5'd22, 5'd11, 16'h3A3A);
    busWrEn = 1'b1;
    repeat (300) @(negedge clk);
    busWrEn = 1'b0;
    waitIdle();
    chk("R8 exactly two frames", 64'(frameCnt - fc), 64'd2);
    chk("R8 first frame untouched", prevFrame, mkFrame(1'b0, 5'd9, 5'd4, 16'hC0DE));
    chk("R8 held command taken when idle", lastFrame, mkFrame(1'b0, 5'd22, 5'd11, 16'h3A3A));

    summary();
    $finish;
  end
endmodule